// File: doc/BRIEF.md
# Block-Mode DMA Transfer Channel

A single DMA channel that copies a block of 16-bit words or bytes from a source address to a destination address over a shared memory bus. Software fills four registers (source base, destination base, unit count and control), then writes the control register with the enable and request bits set. The channel then owns the bus. It holds the CPU for the whole block and moves one unit every two clock cycles: a read phase, then a write phase.

The source and destination pointers each have their own addressing mode and unit width. The bus grant and ready inputs can stretch any phase, so a slow memory adds wait states without losing data. When the last write is accepted, the channel drops the CPU hold, raises a done flag and, if enabled, an interrupt. In repeated-block mode the channel stays enabled, so the next request runs the same programmed block again.

Top module: `dma_block_chan`

## Requirements
- R1: With grant and ready held high, each unit takes exactly two cycles: a read phase (`bus_we_o`=0), then a write phase (`bus_we_o`=1). A block of N units keeps `cpu_hold_o` high for exactly 2N cycles.
- R2: The size register (index 2) holds the unit count in the range 1 to 4096. A write of 0 reads back as 1, a write above 4096 reads back as 4096, and the reset value is 1.
- R3: The addressing mode fields are control bits [3:2] for the source and [5:4] for the destination: 00 or 01 fixed, 10 decrement, 11 increment. A pointer steps by 2 in word mode and by 1 in byte mode, once per unit.
- R4: A word access (`bus_byte_o`=0) always drives address bit 0 low, whatever the base address.
- R5: Control bit 6 selects a byte source and bit 7 a byte destination, each on its own. Byte data is right-aligned on the bus. A byte read feeds a word write zero-extended, and a word read feeds a byte write through its low byte.
- R6: Writing control bit 1 (request) starts a block only if the same write sets bit 0 (enable). The request bit is never stored and always reads back as 0. A request with enable low starts nothing.
- R7: `cpu_hold_o` rises on the cycle after the starting write and falls on the cycle after the last write phase is accepted.
- R8: The done flag (control bit 10, `done_o`) sets on the cycle after the final write. A new block start clears it, and so does a control write with bit 10 at 0. `irq_o` equals done ANDed with control bit 9.
- R9: With control bit 8 (repeat) set, enable stays set after a block, and a later request re-runs the block from the programmed bases and size. Without it, enable clears when the block completes.
- R10: While `bus_gnt_i` and `bus_rdy_i` are not both high, the current phase holds its address, direction and width unchanged and does not advance.
- R11: Register writes made while the channel is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register index: 0 source, 1 destination, 2 size, 3 control |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i` (combinational) |
| bus_req_o | output | 1 | Bus request, high for the whole block |
| bus_we_o | output | 1 | 1 in a write phase, 0 in a read phase |
| bus_byte_o | output | 1 | Byte access when high, word access when low |
| bus_addr_o | output | 16 | Byte address of the current phase |
| bus_wdata_o | output | 16 | Write data, right-aligned for bytes |
| bus_rdata_i | input | 16 | Read data, right-aligned for bytes |
| bus_gnt_i | input | 1 | Bus grant |
| bus_rdy_i | input | 1 | Phase completes when high together with grant |
| cpu_hold_o | output | 1 | Stalls the CPU while a block runs |
| done_o | output | 1 | Block-complete flag |
| irq_o | output | 1 | Block-complete interrupt (masked done) |

## Verification
On every cycle, the assertions check that reads and writes strictly alternate, that word addresses are even, that a stalled phase keeps its address and direction, that the hold drops only after an accepted write, and that done and the interrupt follow the completion. The bench scenarios cover what needs a memory image or a cycle count: the data moved under each mix of addressing mode and unit width, the exact 2N hold length, size clamping, the request-without-enable case, repeat rearming, and register writes ignored mid-block.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    AM_FIX0 = 2'b00,
    AM_FIX1 = 2'b01,
    AM_DEC  = 2'b10,
    AM_INC  = 2'b11
  } addr_mode_e;

  typedef struct packed {
    logic       irq_en;
    logic       rpt;
    logic       dst_byte;
    logic       src_byte;
    addr_mode_e dst_mode;
    addr_mode_e src_mode;
    logic       en;
  } chan_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WR
  } seq_state_e;

  localparam logic [1:0] REG_SRC  = 2'd0;
  localparam logic [1:0] REG_DST  = 2'd1;
  localparam logic [1:0] REG_SIZE = 2'd2;
  localparam logic [1:0] REG_CTRL = 2'd3;

  localparam int unsigned CB_EN    = 0;
  localparam int unsigned CB_REQ   = 1;
  localparam int unsigned CB_SMODE = 2;
  localparam int unsigned CB_DMODE = 4;
  localparam int unsigned CB_SBYTE = 6;
  localparam int unsigned CB_DBYTE = 7;
  localparam int unsigned CB_RPT   = 8;
  localparam int unsigned CB_IRQEN = 9;
  localparam int unsigned CB_DONE  = 10;
endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_chan_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              step_i,
  input  addr_mode_e        mode_i,
  input  logic              byte_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] cur_q;
  logic [ADDR_W-1:0] stride;

  assign stride = byte_i ? ADDR_W'(1) : ADDR_W'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
    end else if (load_i) begin
      cur_q <= base_i;
    end else if (step_i) begin
      unique case (mode_i)
        AM_INC:  cur_q <= cur_q + stride;
        AM_DEC:  cur_q <= cur_q - stride;
        default: cur_q <= cur_q;
      endcase
    end
  end

  // word accesses are forced even
  assign addr_o = byte_i ? cur_q : {cur_q[ADDR_W-1:1], 1'b0};
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned MAX_UNITS = 4096,
  parameter int unsigned CNT_W     = $clog2(MAX_UNITS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              finish_i,
  output logic [ADDR_W-1:0] src_base_o,
  output logic [ADDR_W-1:0] dst_base_o,
  output logic [CNT_W-1:0]  size_o,
  output chan_cfg_t         cfg_o,
  output logic              start_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  size_q;
  chan_cfg_t         cfg_q;
  logic              done_q;
  logic              wr_ok;

  function automatic logic [CNT_W-1:0] clamp_size(input logic [DATA_W-1:0] w);
    if (w == '0)                     return CNT_W'(1);
    else if (w > DATA_W'(MAX_UNITS)) return CNT_W'(MAX_UNITS);
    else                             return w[CNT_W-1:0];
  endfunction

  assign wr_ok   = we_i && !busy_i;
  assign start_o = wr_ok && (addr_i == REG_CTRL) && wdata_i[CB_REQ] && wdata_i[CB_EN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      dst_q  <= '0;
      size_q <= CNT_W'(1);
      cfg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (wr_ok) begin
        unique case (addr_i)
          REG_SRC:  src_q  <= wdata_i[ADDR_W-1:0];
          REG_DST:  dst_q  <= wdata_i[ADDR_W-1:0];
          REG_SIZE: size_q <= clamp_size(wdata_i);
          default: begin
            cfg_q.en       <= wdata_i[CB_EN];
            cfg_q.src_mode <= addr_mode_e'(wdata_i[CB_SMODE +: 2]);
            cfg_q.dst_mode <= addr_mode_e'(wdata_i[CB_DMODE +: 2]);
            cfg_q.src_byte <= wdata_i[CB_SBYTE];
            cfg_q.dst_byte <= wdata_i[CB_DBYTE];
            cfg_q.rpt      <= wdata_i[CB_RPT];
            cfg_q.irq_en   <= wdata_i[CB_IRQEN];
            done_q         <= done_q & wdata_i[CB_DONE];
          end
        endcase
      end
      if (start_o) done_q <= 1'b0;
      if (finish_i) begin
        done_q <= 1'b1;
        if (!cfg_q.rpt) cfg_q.en <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_SRC:  rdata_o = DATA_W'(src_q);
      REG_DST:  rdata_o = DATA_W'(dst_q);
      REG_SIZE: rdata_o = DATA_W'(size_q);
      default: begin
        rdata_o[CB_EN]          = cfg_q.en;
        rdata_o[CB_SMODE +: 2]  = cfg_q.src_mode;
        rdata_o[CB_DMODE +: 2]  = cfg_q.dst_mode;
        rdata_o[CB_SBYTE]       = cfg_q.src_byte;
        rdata_o[CB_DBYTE]       = cfg_q.dst_byte;
        rdata_o[CB_RPT]         = cfg_q.rpt;
        rdata_o[CB_IRQEN]       = cfg_q.irq_en;
        rdata_o[CB_DONE]        = done_q;
      end
    endcase
  end

  assign src_base_o = src_q;
  assign dst_base_o = dst_q;
  assign size_o     = size_q;
  assign cfg_o      = cfg_q;
  assign done_o     = done_q;
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  size_i,
  input  logic              src_byte_i,
  input  logic              bus_gnt_i,
  input  logic              bus_rdy_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              busy_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              step_o,
  output logic              finish_o,
  output logic [DATA_W-1:0] data_o
);
  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] data_q;
  logic              adv;

  assign adv = bus_gnt_i && bus_rdy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RD;
          cnt_q   <= size_i;
        end
        ST_RD: if (adv) begin
          data_q  <= src_byte_i ? {{(DATA_W-8){1'b0}}, bus_rdata_i[7:0]} : bus_rdata_i;
          state_q <= ST_WR;
        end
        ST_WR: if (adv) begin
          if (cnt_q == CNT_W'(1)) begin
            state_q <= ST_IDLE;
          end else begin
            cnt_q   <= cnt_q - CNT_W'(1);
            state_q <= ST_RD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = state_q != ST_IDLE;
  assign rd_o     = state_q == ST_RD;
  assign wr_o     = state_q == ST_WR;
  assign step_o   = wr_o && adv;
  assign finish_o = step_o && (cnt_q == CNT_W'(1));
  assign data_o   = data_q;
endmodule

// File: rtl/dma_block_chan.sv
module dma_block_chan
  import dma_chan_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned MAX_UNITS = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic              bus_byte_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_gnt_i,
  input  logic              bus_rdy_i,
  output logic              cpu_hold_o,
  output logic              done_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = $clog2(MAX_UNITS + 1);

  logic [ADDR_W-1:0] src_base, dst_base;
  logic [CNT_W-1:0]  size;
  chan_cfg_t         cfg;
  logic              start, done, busy, rd, wr, step, finish;
  logic [DATA_W-1:0] data;

  logic [ADDR_W-1:0] base_a [2];
  logic [ADDR_W-1:0] addr_a [2];
  addr_mode_e        mode_a [2];
  logic              byte_a [2];

  dma_chan_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_UNITS(MAX_UNITS), .CNT_W(CNT_W)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .busy_i    (busy),
    .finish_i  (finish),
    .src_base_o(src_base),
    .dst_base_o(dst_base),
    .size_o    (size),
    .cfg_o     (cfg),
    .start_o   (start),
    .done_o    (done)
  );

  dma_chan_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni,
    .start_i    (start),
    .size_i     (size),
    .src_byte_i (cfg.src_byte),
    .bus_gnt_i, .bus_rdy_i, .bus_rdata_i,
    .busy_o     (busy),
    .rd_o       (rd),
    .wr_o       (wr),
    .step_o     (step),
    .finish_o   (finish),
    .data_o     (data)
  );

  assign base_a[0] = src_base;
  assign base_a[1] = dst_base;
  assign mode_a[0] = cfg.src_mode;
  assign mode_a[1] = cfg.dst_mode;
  assign byte_a[0] = cfg.src_byte;
  assign byte_a[1] = cfg.dst_byte;

  // index 0 = source pointer, 1 = destination pointer
  for (genvar g = 0; g < 2; g++) begin : g_ptr
    dma_addr_unit #(.ADDR_W(ADDR_W)) u_ptr (
      .clk_i, .rst_ni,
      .load_i (start),
      .base_i (base_a[g]),
      .step_i (step),
      .mode_i (mode_a[g]),
      .byte_i (byte_a[g]),
      .addr_o (addr_a[g])
    );
  end

  assign bus_req_o   = busy;
  assign bus_we_o    = wr;
  assign bus_byte_o  = rd ? cfg.src_byte : cfg.dst_byte;
  assign bus_addr_o  = rd ? addr_a[0] : addr_a[1];
  assign bus_wdata_o = cfg.dst_byte ? {{(DATA_W-8){1'b0}}, data[7:0]} : data;
  assign cpu_hold_o  = busy;
  assign done_o      = done;
  assign irq_o       = done && cfg.irq_en;
endmodule

// File: rtl/dma_block_chan_chk.sv
module dma_block_chan_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic              bus_byte_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_gnt_i,
  input logic              bus_rdy_i,
  input logic              cpu_hold_o,
  input logic              done_o,
  input logic              irq_o
);
  assert_rd_then_wr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_we_o && bus_gnt_i && bus_rdy_i) |=> (bus_req_o && bus_we_o));

  assert_wr_then_rd_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_we_o && bus_gnt_i && bus_rdy_i) |=> !bus_we_o);

  assert_word_even_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_byte_o) |-> !bus_addr_o[0]);

  assert_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_hold_o) |-> $past(bus_we_o && bus_gnt_i && bus_rdy_i));

  assert_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (!cpu_hold_o && $past(cpu_hold_o)));

  assert_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done_o);

  assert_stall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !(bus_gnt_i && bus_rdy_i)) |=>
      (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_byte_o)));
endmodule

bind dma_block_chan dma_block_chan_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_dma_block_chan.sv
module sim_dma_block_chan;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        bus_req_o, bus_we_o, bus_byte_o;
  logic [15:0] bus_addr_o, bus_wdata_o, bus_rdata_i;
  logic        bus_gnt_i = 1'b0, bus_rdy_i = 1'b0;
  logic        cpu_hold_o, done_o, irq_o;

  logic [7:0] mem [0:1023];
  logic [7:0] ref_mem [0:1023];
  int wait_mode = 0;
  int errors = 0, checks = 0;

  always #4 clk_i = ~clk_i;

  dma_block_chan u0 (.*);

  logic [9:0] bidx;
  assign bidx = bus_addr_o[9:0];
  assign bus_rdata_i = bus_byte_o ? {8'h00, mem[bidx]}
                                  : {mem[{bidx[9:1], 1'b1}], mem[{bidx[9:1], 1'b0}]};

  always @(posedge clk_i)
    if (bus_req_o && bus_we_o && bus_gnt_i && bus_rdy_i) begin
      if (bus_byte_o) mem[bidx] <= bus_wdata_o[7:0];
      else begin
        mem[{bidx[9:1], 1'b0}] <= bus_wdata_o[7:0];
        mem[{bidx[9:1], 1'b1}] <= bus_wdata_o[15:8];
      end
    end

  always @(negedge clk_i)
    case (wait_mode)
      0: begin bus_gnt_i = 1'b1; bus_rdy_i = 1'b1; end
      1: begin bus_gnt_i = ($urandom % 4) != 0; bus_rdy_i = ($urandom % 3) != 0; end
      default: begin bus_gnt_i = 1'b1; bus_rdy_i = 1'b0; end
    endcase

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  function automatic logic [15:0] ctrlw(bit en, bit req, int sm, int dm, bit sb, bit db, bit rpt, bit ie);
    logic [15:0] w = '0;
    w[0] = en; w[1] = req; w[3:2] = sm[1:0]; w[5:4] = dm[1:0];
    w[6] = sb; w[7] = db; w[8] = rpt; w[9] = ie;
    return w;
  endfunction

  // reference copy of the block on ref_mem
  task automatic model(int s, int d, int n, int sm, int dm, bit sb, bit db);
    for (int i = 0; i < n; i++) begin
      int sa, da;
      logic [15:0] v;
      sa = sb ? s : (s & ~1);
      da = db ? d : (d & ~1);
      v = sb ? {8'h00, ref_mem[sa & 1023]} : {ref_mem[(sa | 1) & 1023], ref_mem[sa & 1023]};
      if (db) ref_mem[da & 1023] = v[7:0];
      else begin
        ref_mem[da & 1023] = v[7:0];
        ref_mem[(da | 1) & 1023] = v[15:8];
      end
      if (sm == 3) s += sb ? 1 : 2; else if (sm == 2) s -= sb ? 1 : 2;
      if (dm == 3) d += db ? 1 : 2; else if (dm == 2) d -= db ? 1 : 2;
    end
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (cpu_hold_o && cyc < 50000) begin
      cyc++;
      @(negedge clk_i);
    end
  endtask

  task automatic mem_check(input string req);
    int mism = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== ref_mem[i]) mism++;
    check(mism == 0, req, "memory bytes differing", mism, 0);
  endtask

  task automatic run_block(input string req, int s, int d, int n, int sm, int dm,
                           bit sb, bit db, bit rpt, bit ie, output int cyc);
    reg_wr(2'd0, 16'(s)); reg_wr(2'd1, 16'(d)); reg_wr(2'd2, 16'(n));
    for (int i = 0; i < 1024; i++) ref_mem[i] = mem[i];
    model(s, d, n, sm, dm, sb, db);
    reg_wr(2'd3, ctrlw(1, 1, sm, dm, sb, db, rpt, ie));
    wait_done(cyc);
    mem_check(req);
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [15:0] rd;
    int cyc;
    void'($urandom(32'd7331));
    for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // reset state
    check(!cpu_hold_o && !bus_req_o, "R7", "hold/req after reset", cpu_hold_o, 0);
    check(!done_o && !irq_o, "R8", "done/irq after reset", done_o, 0);
    reg_rd(2'd3, rd); check(rd == 16'h0, "R6", "ctrl after reset", rd, 0);
    reg_rd(2'd2, rd); check(rd == 16'd1, "R2", "size after reset", rd, 1);

    // R2 clamping
    reg_wr(2'd2, 16'd0);    reg_rd(2'd2, rd); check(rd == 16'd1,    "R2", "size write 0", rd, 1);
    reg_wr(2'd2, 16'd5000); reg_rd(2'd2, rd); check(rd == 16'd4096, "R2", "size write 5000", rd, 4096);
    reg_wr(2'd2, 16'd4096); reg_rd(2'd2, rd); check(rd == 16'd4096, "R2", "size write 4096", rd, 4096);
    reg_wr(2'd2, 16'd7);    reg_rd(2'd2, rd); check(rd == 16'd7,    "R2", "size write 7", rd, 7);

    // R6 request without enable
    reg_wr(2'd3, ctrlw(0, 1, 3, 3, 0, 0, 0, 1));
    repeat (3) begin
      check(!cpu_hold_o && !done_o, "R6", "no start without enable", cpu_hold_o, 0);
      @(negedge clk_i);
    end
    reg_rd(2'd3, rd); check(rd[1:0] == 2'b00, "R6", "req/en readback", rd[1:0], 0);

    // R1/R7/R8 zero-wait word block
    wait_mode = 0;
    run_block("R1", 100, 600, 4, 3, 3, 0, 0, 0, 1, cyc);
    check(cyc == 8, "R1", "hold cycles for 4 units", cyc, 8);
    check(done_o && !cpu_hold_o, "R7", "released with done", cpu_hold_o, 0);
    check(irq_o, "R8", "irq with irq enable", irq_o, 1);
    reg_rd(2'd3, rd); check(rd[0] == 1'b0 && rd[10], "R9", "enable cleared, done set", rd, 16'h400);
    reg_wr(2'd3, 16'h0);
    check(!done_o && !irq_o, "R8", "done cleared by write", done_o, 0);

    run_block("R8", 40, 700, 1, 3, 3, 1, 1, 0, 0, cyc);
    check(cyc == 2, "R1", "hold cycles for 1 unit", cyc, 2);
    check(done_o && !irq_o, "R8", "irq masked", irq_o, 0);

    // R4 odd bases in word mode, R3 fixed/decrement, R5 width mixes
    run_block("R4", 101, 603, 5, 3, 3, 0, 0, 0, 0, cyc);
    run_block("R3", 150, 620, 6, 0, 3, 1, 1, 0, 0, cyc);
    run_block("R3", 400, 640, 6, 2, 1, 0, 0, 0, 0, cyc);
    run_block("R3", 300, 900, 7, 3, 2, 1, 1, 0, 0, cyc);
    run_block("R5", 60, 660, 8, 3, 3, 1, 0, 0, 0, cyc);
    check(cyc == 16, "R1", "hold cycles byte->word", cyc, 16);
    run_block("R5", 80, 680, 8, 3, 3, 0, 1, 0, 0, cyc);

    // R9 repeat rearm
    run_block("R9", 200, 720, 3, 3, 3, 0, 0, 1, 0, cyc);
    reg_rd(2'd3, rd); check(rd[0] && rd[8], "R9", "enable kept in repeat", rd[0], 1);
    for (int i = 200; i < 206; i++) mem[i] = 8'($urandom);
    for (int i = 0; i < 1024; i++) ref_mem[i] = mem[i];
    model(200, 720, 3, 3, 3, 0, 0);
    reg_wr(2'd3, ctrlw(1, 1, 3, 3, 0, 0, 1, 0));
    wait_done(cyc);
    check(cyc == 6, "R9", "rerun uses programmed size", cyc, 6);
    mem_check("R9");

    // R10/R11 stalled block, writes ignored while busy
    wait_mode = 2;
    reg_wr(2'd0, 16'd220); reg_wr(2'd1, 16'd760); reg_wr(2'd2, 16'd2);
    for (int i = 0; i < 1024; i++) ref_mem[i] = mem[i];
    model(220, 760, 2, 3, 3, 0, 0);
    reg_wr(2'd3, ctrlw(1, 1, 3, 3, 0, 0, 0, 0));
    reg_wr(2'd0, 16'd330);
    reg_wr(2'd2, 16'd9);
    repeat (4) @(negedge clk_i);
    check(cpu_hold_o && !bus_we_o && bus_addr_o == 16'd220, "R10", "stalled read address", bus_addr_o, 220);
    reg_rd(2'd0, rd); check(rd == 16'd220, "R11", "source write ignored", rd, 220);
    reg_rd(2'd2, rd); check(rd == 16'd2, "R11", "size write ignored", rd, 2);
    wait_mode = 0;
    wait_done(cyc);
    mem_check("R10");

    // random blocks with random waits
    for (int t = 0; t < 30; t++) begin
      int n, sm, dm, s, d;
      bit sb, db;
      wait_mode = (t % 3 == 0) ? 0 : 1;
      n = 1 + $urandom % 40; sm = $urandom % 4; dm = $urandom % 4;
      sb = $urandom % 2; db = $urandom % 2;
      s = (sm == 2) ? 300 + $urandom % 100 : 20 + $urandom % 100;
      d = (dm == 2) ? 900 + $urandom % 100 : 600 + $urandom % 100;
      run_block("R3", s, d, n, sm, dm, sb, db, 0, 0, cyc);
      if (wait_mode == 0) check(cyc == 2 * n, "R1", "random zero-wait hold cycles", cyc, 2 * n);
      check(done_o && !cpu_hold_o, "R8", "random block done", done_o, 1);
    end

    summary();
  end
endmodule